// File: doc/BRIEF.md
# Exclusive-Mode Outer Cache Tag Controller

This block holds the tags and per-line state of a small set-associative outer cache and sequences the memory commands that keep that state correct. It accepts one read or write request at a time from the inner side. A write carries a two-bit attribute that tells whether it is an inner-cache eviction and whether that eviction is clean. For each request the block looks up the set, decides on hit, miss, victim, write-back and fill, updates the valid and dirty bits, and issues zero, one or two commands on a memory command port. Line data is held elsewhere. This block only produces the tag-side decisions.

A static input `cfg_excl` selects the operating mode. When it is low, the cache behaves as an ordinary inclusive cache that allocates on read. When it is high, a line lives in either the inner cache or this one, but not both. A read hit hands the line back and drops it from this level. A read miss bypasses allocation. Lines evicted from the inner cache are installed on write. In this mode a line can be invalid but still dirty. Such a line keeps answering hits and is the first choice of victim. `cfg_excl` may only change while the block is idle, and is normally changed together with a reset.

The request side is valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. The requester holds its fields stable while `req_valid` is high and not yet accepted. The memory side is command/acknowledge. The block holds a command and its fields until the edge where `mem_cmd_ack` is high. Completion is a one-cycle `done_valid` pulse with `done_hit`.

Top module: `cec_top`

## Requirements
- R1: After reset every line is empty (neither valid nor dirty), `req_ready` is 1, and `mem_cmd_valid` and `done_valid` are 0.
- R2: With `cfg_excl`=0, a read miss picks a victim, fills it with command FILL_ALLOC (code 1) at the line address, and leaves the line valid and clean. Later reads of that line hit with no command, and the line stays valid.
- R3: With `cfg_excl`=1, a read hit on a clean line reports a hit, issues no command and clears the line's valid bit. A following read of the same line is a miss.
- R4: With `cfg_excl`=1, a read hit on a dirty line issues WB (code 0) at the line address and then FILL_PASS (code 2) at the request address. It clears the valid bit and keeps the dirty bit.
- R5: A line that is invalid but dirty still hits on later accesses to its address.
- R6: With `cfg_excl`=1, a read miss issues only FILL_PASS at the request address and allocates no line. FILL_ALLOC is never issued in this mode.
- R7: A write hit leaves the line valid. It sets the dirty bit, except when the attribute is 2'b11, in which case the dirty bit keeps its value.
- R8: A write miss with attribute bit 0 set (eviction) installs the line valid with no fill. The line is dirty unless attribute bit 1 (clean eviction) is set.
- R9: A write miss with attribute bit 0 clear allocates nothing and issues WRITE_THRU (code 3) at the request address.
- R10: The victim is the lowest-numbered invalid-dirty way if any exists. Otherwise it is the lowest-numbered empty way. Otherwise it is the set's round-robin pointer, which starts at way 0 and advances only when it is used. A dirty victim is first written back with WB at its own line address.
- R11: `req_ready` is low from acceptance until completion. A command holds its op and address until acknowledged. `done_valid` is a single-cycle pulse.
- R12: A request yields at most two commands, and a WB always comes before the other command. Line addresses have the offset bits zeroed. FILL_PASS and WRITE_THRU carry the full request address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_excl | input | 1 | 1 selects exclusive mode, 0 selects inclusive mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_attr | input | 2 | Write attribute: bit 0 eviction, bit 1 clean eviction |
| req_addr | input | ADDR_W | Byte address of the request |
| done_valid | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Request hit in this cache (valid with done_valid) |
| mem_cmd_valid | output | 1 | Memory command present |
| mem_cmd_ack | input | 1 | Memory accepts the command on this edge |
| mem_cmd_op | output | 2 | 0 WB, 1 FILL_ALLOC, 2 FILL_PASS, 3 WRITE_THRU |
| mem_cmd_addr | output | ADDR_W | Command address |

## Verification
The bench builds the block with 2 ways, 4 sets, 12-bit addresses and 16-byte lines. With only two ways, a few writes to one set reach every victim path: the invalid-dirty preference over an empty way, the empty-way choice, and both positions of the round-robin pointer, including a dirty round-robin victim that forces a write-back. Four sets let the exclusive-mode scenarios, the write-through case and the inclusive-mode sequence each use a set of their own. Memory acknowledges after a delay, so every command is held for several cycles.

// File: rtl/cec_pkg.sv
package cec_pkg;
  typedef enum logic [1:0] {
    CMD_WB         = 2'd0,
    CMD_FILL_ALLOC = 2'd1,
    CMD_FILL_PASS  = 2'd2,
    CMD_WRITE_THRU = 2'd3
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_OP2,
    ST_DONE
  } ctl_state_e;
endpackage

// File: rtl/cec_tag_store.sv
module cec_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
  output logic [WAYS-1:0]               rd_valid,
  output logic [WAYS-1:0]               rd_dirty,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [WAY_W-1:0]              wr_way,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic                          wr_valid,
  input  logic                          wr_dirty
);
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0]            val_q [SETS];
  logic [WAYS-1:0]            drt_q [SETS];

  // Tags carry no reset: a line is only looked at when valid or dirty.
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        drt_q[s] <= '0;
      end
    end else if (wr_en) begin
      val_q[wr_idx][wr_way] <= wr_valid;
      drt_q[wr_idx][wr_way] <= wr_dirty;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = val_q[rd_idx];
  assign rd_dirty = drt_q[rd_idx];
endmodule

// File: rtl/cec_way_select.sv
module cec_way_select #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 23,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       chk_en,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0]            way_dirty,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [WAY_W-1:0]           rr_ptr,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           vic_way,
  output logic                       vic_use_rr
);
  logic [WAYS-1:0] hit_vec;
  logic [WAYS-1:0] inv_dirty;
  logic [WAYS-1:0] empty;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    // An invalid but dirty line still answers for its address.
    assign hit_vec[w]   = (way_tag[w] == req_tag) && (way_valid[w] || way_dirty[w]);
    assign inv_dirty[w] = !way_valid[w] && way_dirty[w];
    assign empty[w]     = !way_valid[w] && !way_dirty[w];
  end

  always_comb begin
    hit     = |hit_vec;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  always_comb begin
    vic_way    = rr_ptr;
    vic_use_rr = 1'b1;
    if (|inv_dirty) begin
      vic_use_rr = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (inv_dirty[w]) vic_way = WAY_W'(w);
      end
    end else if (|empty) begin
      vic_use_rr = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (empty[w]) vic_way = WAY_W'(w);
      end
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $onehot0(hit_vec)); // R5
  AST_VICTIM_PREF: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && (|inv_dirty)) |-> (!way_valid[vic_way] && way_dirty[vic_way])); // R10
endmodule

// File: rtl/cec_ctrl.sv
module cec_ctrl
  import cec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_excl,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [1:0]                 req_attr,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       done_valid,
  output logic                       done_hit,
  output logic                       mem_cmd_valid,
  input  logic                       mem_cmd_ack,
  output logic [1:0]                 mem_cmd_op,
  output logic [ADDR_W-1:0]          mem_cmd_addr,
  output logic [IDX_W-1:0]           look_idx,
  output logic [TAG_W-1:0]           look_tag,
  output logic                       look_active,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0]            way_dirty,
  input  logic                       hit,
  input  logic [WAY_W-1:0]           hit_way,
  input  logic [WAY_W-1:0]           vic_way,
  input  logic                       vic_use_rr,
  output logic [WAY_W-1:0]           rr_ptr,
  output logic                       tw_en,
  output logic [WAY_W-1:0]           tw_way,
  output logic [TAG_W-1:0]           tw_tag,
  output logic                       tw_valid,
  output logic                       tw_dirty
);
  ctl_state_e        st_q;
  logic              wr_q;
  logic [1:0]        attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              hit_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic              op2_pend_q;
  mem_op_e           op2_q;
  logic [ADDR_W-1:0] op2_addr_q;
  logic [WAY_W-1:0]  rr_q [SETS];

  logic              pl_wb;
  logic [ADDR_W-1:0] pl_wb_addr;
  logic              pl_op2v;
  mem_op_e           pl_op2;
  logic [ADDR_W-1:0] pl_op2_addr;
  logic              pl_upd;
  logic              rr_adv;
  logic              hit_dirty;
  logic              vic_dirty;

  function automatic logic [ADDR_W-1:0] line_of(input logic [TAG_W-1:0] t,
                                                input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction

  assign look_tag    = addr_q[ADDR_W-1 -: TAG_W];
  assign look_idx    = addr_q[OFF_W +: IDX_W];
  assign look_active = (st_q == ST_LOOK);
  assign rr_ptr      = rr_q[look_idx];
  assign hit_dirty   = way_dirty[hit_way];
  assign vic_dirty   = way_dirty[vic_way];

  // Decision made in the lookup cycle; tag state is written at its end.
  always_comb begin
    pl_wb       = 1'b0;
    pl_wb_addr  = line_of(way_tag[vic_way], look_idx);
    pl_op2v     = 1'b0;
    pl_op2      = CMD_FILL_PASS;
    pl_op2_addr = addr_q;
    pl_upd      = 1'b0;
    tw_way      = vic_way;
    tw_tag      = look_tag;
    tw_valid    = 1'b1;
    tw_dirty    = 1'b0;
    rr_adv      = 1'b0;
    if (!wr_q) begin
      if (hit) begin
        if (cfg_excl) begin
          pl_wb      = hit_dirty;
          pl_wb_addr = line_of(look_tag, look_idx);
          pl_op2v    = hit_dirty;
          pl_upd     = 1'b1;
          tw_way     = hit_way;
          tw_valid   = 1'b0;
          tw_dirty   = hit_dirty;
        end
      end else if (cfg_excl) begin
        pl_op2v = 1'b1;
      end else begin
        pl_wb       = vic_dirty;
        pl_op2v     = 1'b1;
        pl_op2      = CMD_FILL_ALLOC;
        pl_op2_addr = line_of(look_tag, look_idx);
        pl_upd      = 1'b1;
        rr_adv      = vic_use_rr;
      end
    end else begin
      if (hit) begin
        pl_upd   = 1'b1;
        tw_way   = hit_way;
        tw_dirty = (attr_q == 2'b11) ? hit_dirty : 1'b1;
      end else if (attr_q[0]) begin
        pl_wb    = vic_dirty;
        pl_upd   = 1'b1;
        tw_dirty = !attr_q[1];
        rr_adv   = vic_use_rr;
      end else begin
        pl_op2v = 1'b1;
        pl_op2  = CMD_WRITE_THRU;
      end
    end
  end

  assign tw_en = look_active && pl_upd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      wr_q       <= 1'b0;
      attr_q     <= '0;
      addr_q     <= '0;
      hit_q      <= 1'b0;
      wb_addr_q  <= '0;
      op2_pend_q <= 1'b0;
      op2_q      <= CMD_FILL_PASS;
      op2_addr_q <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          wr_q   <= req_write;
          attr_q <= req_attr;
          addr_q <= req_addr;
          st_q   <= ST_LOOK;
        end
        ST_LOOK: begin
          hit_q      <= hit;
          wb_addr_q  <= pl_wb_addr;
          op2_pend_q <= pl_op2v;
          op2_q      <= pl_op2;
          op2_addr_q <= pl_op2_addr;
          if (rr_adv) begin
            rr_q[look_idx] <= (rr_q[look_idx] == WAY_W'(WAYS - 1)) ? '0
                            : rr_q[look_idx] + WAY_W'(1);
          end
          st_q <= pl_wb ? ST_WB : (pl_op2v ? ST_OP2 : ST_DONE);
        end
        ST_WB: if (mem_cmd_ack) st_q <= op2_pend_q ? ST_OP2 : ST_DONE;
        ST_OP2: if (mem_cmd_ack) st_q <= ST_DONE;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign done_valid    = (st_q == ST_DONE);
  assign done_hit      = hit_q;
  assign mem_cmd_valid = (st_q == ST_WB) || (st_q == ST_OP2);
  assign mem_cmd_op    = (st_q == ST_WB) ? CMD_WB : op2_q;
  assign mem_cmd_addr  = (st_q == ST_WB) ? wb_addr_q : op2_addr_q;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ack) |=> (mem_cmd_valid && $stable(mem_cmd_op)
                                         && $stable(mem_cmd_addr))); // R11
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R11
  AST_EXCL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_excl && mem_cmd_valid) |-> (mem_cmd_op != CMD_FILL_ALLOC)); // R6
  AST_RD_HIT_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (look_active && cfg_excl && !wr_q && hit) |=> !way_valid[$past(hit_way)]); // R3
  AST_WR_CLEAN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (look_active && wr_q && hit && attr_q == 2'b11)
      |=> (way_dirty[$past(hit_way)] == $past(hit_dirty))); // R7
endmodule

// File: rtl/cec_top.sv
module cec_top #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_excl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_attr,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              done_valid,
  output logic              done_hit,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ack,
  output logic [1:0]        mem_cmd_op,
  output logic [ADDR_W-1:0] mem_cmd_addr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0]           look_idx;
  logic [TAG_W-1:0]           look_tag;
  logic                       look_active;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAYS-1:0]            way_valid;
  logic [WAYS-1:0]            way_dirty;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way;
  logic [WAY_W-1:0]           vic_way;
  logic                       vic_use_rr;
  logic [WAY_W-1:0]           rr_ptr;
  logic                       tw_en;
  logic [WAY_W-1:0]           tw_way;
  logic [TAG_W-1:0]           tw_tag;
  logic                       tw_valid;
  logic                       tw_dirty;

  cec_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_tag(way_tag), .rd_valid(way_valid), .rd_dirty(way_dirty),
    .wr_en(tw_en), .wr_idx(look_idx), .wr_way(tw_way), .wr_tag(tw_tag),
    .wr_valid(tw_valid), .wr_dirty(tw_dirty)
  );

  cec_way_select #(.WAYS(WAYS), .TAG_W(TAG_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .chk_en(look_active),
    .way_tag(way_tag), .way_valid(way_valid), .way_dirty(way_dirty),
    .req_tag(look_tag), .rr_ptr(rr_ptr),
    .hit(hit), .hit_way(hit_way), .vic_way(vic_way), .vic_use_rr(vic_use_rr)
  );

  cec_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_excl(cfg_excl),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_attr(req_attr), .req_addr(req_addr),
    .done_valid(done_valid), .done_hit(done_hit),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ack(mem_cmd_ack),
    .mem_cmd_op(mem_cmd_op), .mem_cmd_addr(mem_cmd_addr),
    .look_idx(look_idx), .look_tag(look_tag), .look_active(look_active),
    .way_tag(way_tag), .way_valid(way_valid), .way_dirty(way_dirty),
    .hit(hit), .hit_way(hit_way), .vic_way(vic_way), .vic_use_rr(vic_use_rr),
    .rr_ptr(rr_ptr),
    .tw_en(tw_en), .tw_way(tw_way), .tw_tag(tw_tag),
    .tw_valid(tw_valid), .tw_dirty(tw_dirty)
  );
endmodule

// File: tb/tb_cec_top.sv
module tb_cec_top;
  localparam int AW = 12;
  localparam logic [1:0] WB = 2'd0, FA = 2'd1, FP = 2'd2, WT = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_excl = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_attr = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic          done_valid;
  logic          done_hit;
  logic          mem_cmd_valid;
  logic          mem_cmd_ack = 1'b0;
  logic [1:0]    mem_cmd_op;
  logic [AW-1:0] mem_cmd_addr;

  int checks = 0;
  int fails  = 0;
  int cmd_total = 0;
  logic [1:0]    log_op   [8];
  logic [AW-1:0] log_addr [8];

  always #2 clk = ~clk;

  cec_top #(.ADDR_W(AW), .OFF_W(4), .SETS(4), .WAYS(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_excl(cfg_excl),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_attr(req_attr), .req_addr(req_addr),
    .done_valid(done_valid), .done_hit(done_hit),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ack(mem_cmd_ack),
    .mem_cmd_op(mem_cmd_op), .mem_cmd_addr(mem_cmd_addr)
  );

  function automatic logic [AW-1:0] mk(input int t, input int i);
    return AW'((t << 6) | (i << 4));
  endfunction

  function automatic logic [49:0] ent(input int rq, input logic wr, input logic [1:0] at,
      input logic [AW-1:0] a, input logic h, input int n, input logic [1:0] o0,
      input logic [AW-1:0] a0, input logic [1:0] o1, input logic [AW-1:0] a1);
    return {4'(rq), wr, at, a, h, 2'(n), o0, a0, o1, a1};
  endfunction

  // Exclusive-mode scenario, walked in order after one reset.
  localparam logic [49:0] TBL [20] = '{
    ent(8,  1, 2'b01, mk(1,0), 0, 0, 0, 0, 0, 0),                      // R8 dirty install
    ent(4,  0, 2'b00, mk(1,0), 1, 2, WB, mk(1,0), FP, mk(1,0)),        // R4
    ent(5,  0, 2'b00, mk(1,0), 1, 2, WB, mk(1,0), FP, mk(1,0)),        // R5 invalid-dirty hits
    ent(10, 1, 2'b11, mk(2,0), 0, 1, WB, mk(1,0), 0, 0),               // R10 inv-dirty before empty
    ent(3,  0, 2'b00, mk(2,0), 1, 0, 0, 0, 0, 0),                      // R3 clean hit
    ent(6,  0, 2'b00, mk(2,0), 0, 1, FP, mk(2,0), 0, 0),               // R6 miss after invalidate
    ent(8,  1, 2'b11, mk(3,0), 0, 0, 0, 0, 0, 0),                      // R8 clean install
    ent(7,  1, 2'b11, mk(3,0), 1, 0, 0, 0, 0, 0),                      // R7 keep clean
    ent(7,  0, 2'b00, mk(3,0), 1, 0, 0, 0, 0, 0),                      // R7 still clean
    ent(8,  1, 2'b11, mk(4,0), 0, 0, 0, 0, 0, 0),                      // R8
    ent(7,  1, 2'b00, mk(4,0), 1, 0, 0, 0, 0, 0),                      // R7 plain write dirties
    ent(7,  0, 2'b00, mk(4,0), 1, 2, WB, mk(4,0), FP, mk(4,0)),        // R7 dirty observed
    ent(9,  1, 2'b00, mk(5,1)+4, 0, 1, WT, mk(5,1)+4, 0, 0),           // R9 R12 full address
    ent(9,  0, 2'b00, mk(5,1), 0, 1, FP, mk(5,1), 0, 0),               // R9 no allocation
    ent(8,  1, 2'b11, mk(1,2), 0, 0, 0, 0, 0, 0),                      // R8
    ent(8,  1, 2'b01, mk(2,2), 0, 0, 0, 0, 0, 0),                      // R8
    ent(10, 1, 2'b11, mk(3,2), 0, 0, 0, 0, 0, 0),                      // R10 round-robin way 0
    ent(10, 1, 2'b11, mk(4,2), 0, 1, WB, mk(2,2), 0, 0),               // R10 round-robin way 1
    ent(10, 0, 2'b00, mk(3,2), 1, 0, 0, 0, 0, 0),                      // R10 replacement landed
    ent(6,  0, 2'b00, mk(2,2), 0, 1, FP, mk(2,2), 0, 0)                // R6
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Memory model: acknowledge after a delay; check commands hold (R11).
  initial begin
    int dly = 0;
    bit have_prev = 0;
    logic [1:0] p_op = '0;
    logic [AW-1:0] p_addr = '0;
    forever begin
      @(negedge clk);
      if (mem_cmd_ack) begin
        mem_cmd_ack = 1'b0;
        have_prev = 0;
      end else if (mem_cmd_valid) begin
        if (have_prev)
          chk(mem_cmd_op == p_op && mem_cmd_addr == p_addr, 11, "cmd hold",
              {mem_cmd_op, 8'h0, mem_cmd_addr}, {p_op, 8'h0, p_addr});
        p_op = mem_cmd_op;
        p_addr = mem_cmd_addr;
        have_prev = 1;
        if (dly == 2) begin
          mem_cmd_ack = 1'b1;
          dly = 0;
        end else dly++;
      end
    end
  end

  always @(posedge clk) begin
    if (mem_cmd_valid && mem_cmd_ack) begin
      log_op[cmd_total[2:0]] = mem_cmd_op;
      log_addr[cmd_total[2:0]] = mem_cmd_addr;
      cmd_total++;
    end
  end

  task automatic run_req(input int rq, input logic wr, input logic [1:0] at,
      input logic [AW-1:0] a, input logic h, input int n, input logic [1:0] o0,
      input logic [AW-1:0] a0, input logic [1:0] o1, input logic [AW-1:0] a1);
    int start;
    int waited;
    int got;
    @(negedge clk);
    chk(req_ready == 1'b1, 11, "ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1;
    req_write = wr;
    req_attr  = at;
    req_addr  = a;
    start = cmd_total;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, 11, "ready low while busy", 32'(req_ready), 0);
    waited = 0;
    while (!done_valid && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    chk(done_valid == 1'b1, rq, "completion", 32'(done_valid), 1);
    got = cmd_total - start;
    chk(done_hit == h, rq, "hit", 32'(done_hit), 32'(h));
    chk(got == n, 12, "command count", 32'(got), 32'(n));
    if (got == n && n >= 1)
      chk(log_op[start[2:0]] == o0 && log_addr[start[2:0]] == a0, rq, "first command",
          {log_op[start[2:0]], 8'h0, log_addr[start[2:0]]}, {o0, 8'h0, a0});
    if (got == n && n == 2)
      chk(log_op[3'(start + 1)] == o1 && log_addr[3'(start + 1)] == a1, rq, "second command",
          {log_op[3'(start + 1)], 8'h0, log_addr[3'(start + 1)]}, {o1, 8'h0, a1});
    @(negedge clk);
    chk(done_valid == 1'b0, 11, "done pulse width", 32'(done_valid), 0);
  endtask

  task automatic do_reset(input logic excl);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_excl = excl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, 1, "ready after reset", 32'(req_ready), 1);
    chk(mem_cmd_valid == 1'b0, 1, "no command after reset", 32'(mem_cmd_valid), 0);
    chk(done_valid == 1'b0, 1, "no done after reset", 32'(done_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    foreach (TBL[k]) begin
      logic [49:0] e;
      e = TBL[k];
      run_req(int'(e[49:46]), e[45], e[44:43], e[42:31], e[30], int'(e[29:28]),
              e[27:26], e[25:14], e[13:12], e[11:0]);
    end

    // Inclusive mode in set 1 (R1, R2, R10).
    do_reset(1'b0);
    run_req(1,  0, 2'b00, mk(1,1)+8, 0, 1, FA, mk(1,1), 0, 0);        // R1 empty, R2 fill line addr
    run_req(2,  0, 2'b00, mk(1,1), 1, 0, 0, 0, 0, 0);                 // R2 hit
    run_req(2,  0, 2'b00, mk(1,1), 1, 0, 0, 0, 0, 0);                 // R2 stays valid
    run_req(7,  1, 2'b00, mk(1,1), 1, 0, 0, 0, 0, 0);                 // R7 dirty
    run_req(10, 0, 2'b00, mk(2,1), 0, 1, FA, mk(2,1), 0, 0);          // R10 empty way
    run_req(10, 0, 2'b00, mk(3,1), 0, 2, WB, mk(1,1), FA, mk(3,1));   // R10 dirty rr victim
    run_req(10, 0, 2'b00, mk(1,1), 0, 1, FA, mk(1,1), 0, 0);          // R10 pointer advanced
    run_req(2,  0, 2'b00, mk(3,1), 1, 0, 0, 0, 0, 0);                 // R2

    // Exclusive write miss without eviction on fresh reset (R9).
    do_reset(1'b1);
    run_req(9,  1, 2'b10, mk(7,3)+12, 0, 1, WT, mk(7,3)+12, 0, 0);    // R9
    run_req(6,  0, 2'b00, mk(7,3), 0, 1, FP, mk(7,3), 0, 0);          // R6

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule